// File: doc/BRIEF.md
# Persistent Interrupt Pending Flags for a Buffered Peripheral

This block produces the receive and transmit interrupt requests of a peripheral that has a receive FIFO and a transmit FIFO. It compares each FIFO's fill count with a level picked by a 2-bit select field. The result is a source condition for each direction. A true condition sets a pending flag that software can see. The flag is persistent: a write-one-to-clear from software only takes effect once the source condition has gone away. Software therefore has to service the data register first. For receive, it reads until the count falls below the selected level. For transmit, it writes until the count is above the selected level. Only then does clearing the flag work.

The FIFO counts come from the FIFOs themselves. The read strobe on the receive data register and the write strobe on the transmit data register are applied as a lookahead. The access made in the current cycle is already counted when the condition is evaluated. A clear that arrives in the same cycle as the access that resolves the condition therefore succeeds. A drain mode makes the receive condition "any unread entry", whatever the select field says. While the module is disabled, both conditions are forced inactive so that stale flags can be cleared. No data passes through this block, so every pin is a plain control or status signal and none needs valid/ready back-pressure.

Top module: `irq_persist_flags`

## Requirements
- R1: A pending flag becomes 1 on the clock edge after any cycle in which its condition is true. It stays 1 until it is cleared as R2 allows.
- R2: A clear for a direction happens when `clr_we` is 1 and the direction's bit in `clr_mask` is 1 (bit 0 is receive, bit 1 is transmit). It clears the flag at the next edge only if the condition is false in that cycle. A clear issued while the condition is true leaves the flag at 1.
- R3: The receive condition uses the effective count, with DEPTH=8. For `rx_sel` 00 it is true when the count is at least 1. For 01 it is true when the count is at least 4. For 10 it is true when the count is at least 6. For 11 it is true when the count is 8.
- R4: The receive effective count is `rx_level` minus 1 when `rx_rd` is 1 and `rx_level` is nonzero. Otherwise it is `rx_level`.
- R5: The transmit condition uses the effective count of entries in use. For `tx_sel` 00 it is true when the count is below 8. For 01 it is true when the count is 0. For 10 it is true when the count is at most 4. For 11 it is true when the count is 0 and `tx_shift_busy` is 0.
- R6: The transmit effective count is `tx_level` plus 1 when `tx_wr` is 1 and `tx_level` is below 8. Otherwise it is `tx_level`.
- R7: Suppose the transmit FIFO is empty and the shifter is idle. Then `tx_pend` becomes 1 on the edge after `mod_en` goes to 1, for every value of `tx_sel`.
- R8: When `rx_drain_all` is 1, the receive condition is true exactly when the effective count is nonzero, whatever `rx_sel` says.
- R9: `rx_irq` is `rx_pend` AND `rx_ie`, and `tx_irq` is `tx_pend` AND `tx_ie`. Setting an enable to 0 leaves the pending flag unchanged.
- R10: While `mod_en` is 0, both conditions are false, so a clear removes either flag at the next edge.
- R11: After reset, both pending flags and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | Module enable |
| rx_sel | input | 2 | Receive level select |
| tx_sel | input | 2 | Transmit level select |
| rx_drain_all | input | 1 | Receive condition becomes "any unread entry" |
| rx_level | input | 4 | Entries held in the receive FIFO |
| rx_rd | input | 1 | Receive data register read this cycle |
| tx_level | input | 4 | Entries in use in the transmit FIFO |
| tx_wr | input | 1 | Transmit data register write this cycle |
| tx_shift_busy | input | 1 | Transmit shifter still sending |
| clr_we | input | 1 | Write strobe of the clear register |
| clr_mask | input | 2 | Write-one-to-clear bits: 0 receive, 1 transmit |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_pend | output | 1 | Receive pending flag |
| tx_pend | output | 1 | Transmit pending flag |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as the data access that takes the count across the threshold. Here the lookahead decides whether the flag survives. A clear one cycle early or late gives a different result. The stimulus sets each FIFO to exactly the boundary count for each select value. It then issues the read or write strobe together with the clear, and repeats the test with the strobe alone. A long stretch of random levels, strobes, selects and enables follows, checked every cycle against the reference model.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  typedef enum logic [1:0] {
    RXS_ANY   = 2'b00,
    RXS_HALF  = 2'b01,
    RXS_3Q    = 2'b10,
    RXS_FULL  = 2'b11
  } rx_sel_e;

  typedef enum logic [1:0] {
    TXS_ROOM  = 2'b00,
    TXS_EMPTY = 2'b01,
    TXS_LOW   = 2'b10,
    TXS_IDLE  = 2'b11
  } tx_sel_e;

  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;
  localparam int NDIR   = 2;
endpackage

// File: rtl/irq_rx_cond.sv
module irq_rx_cond
  import irq_flag_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          en,
  input  logic [CW-1:0] level,
  input  logic          rd,
  input  logic [1:0]    sel,
  input  logic          drain_all,
  output logic          cond
);
  localparam logic [CW-1:0] L_ONE  = CW'(1);
  localparam logic [CW-1:0] L_HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] L_3Q   = CW'((3 * DEPTH) / 4);
  localparam logic [CW-1:0] L_FULL = CW'(DEPTH);

  logic [CW-1:0] eff;
  logic          hit;

  // count as it stands once this cycle's read is taken
  always_comb begin
    eff = level;
    if (rd && (level != '0)) eff = level - L_ONE;
  end

  always_comb begin
    unique case (rx_sel_e'(sel))
      RXS_ANY:  hit = (eff >= L_ONE);
      RXS_HALF: hit = (eff >= L_HALF);
      RXS_3Q:   hit = (eff >= L_3Q);
      RXS_FULL: hit = (eff >= L_FULL);
      default:  hit = 1'b0;
    endcase
    if (drain_all) hit = (eff != '0);
    cond = en && hit;
  end
endmodule

// File: rtl/irq_tx_cond.sv
module irq_tx_cond
  import irq_flag_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          en,
  input  logic [CW-1:0] level,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic          shift_busy,
  output logic          cond
);
  localparam logic [CW-1:0] L_ONE  = CW'(1);
  localparam logic [CW-1:0] L_HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] L_FULL = CW'(DEPTH);

  logic [CW-1:0] eff;
  logic          hit;

  // count as it stands once this cycle's write is taken
  always_comb begin
    eff = level;
    if (wr && (level < L_FULL)) eff = level + L_ONE;
  end

  always_comb begin
    unique case (tx_sel_e'(sel))
      TXS_ROOM:  hit = (eff < L_FULL);
      TXS_EMPTY: hit = (eff == '0);
      TXS_LOW:   hit = (eff <= L_HALF);
      TXS_IDLE:  hit = (eff == '0) && !shift_busy;
      default:   hit = 1'b0;
    endcase
    cond = en && hit;
  end
endmodule

// File: rtl/irq_pend_flag.sv
module irq_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clr,
  output logic pend
);
  // set wins over clear; a clear only lands once the source is gone
  always_ff @(posedge clk) begin
    if (!rst_n)    pend <= 1'b0;
    else if (cond) pend <= 1'b1;
    else if (clr)  pend <= 1'b0;
  end
endmodule

// File: rtl/irq_persist_flags.sv
module irq_persist_flags
  import irq_flag_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mod_en,
  input  logic [1:0]    rx_sel,
  input  logic [1:0]    tx_sel,
  input  logic          rx_drain_all,
  input  logic [CW-1:0] rx_level,
  input  logic          rx_rd,
  input  logic [CW-1:0] tx_level,
  input  logic          tx_wr,
  input  logic          tx_shift_busy,
  input  logic          clr_we,
  input  logic [1:0]    clr_mask,
  input  logic          rx_ie,
  input  logic          tx_ie,
  output logic          rx_pend,
  output logic          tx_pend,
  output logic          rx_irq,
  output logic          tx_irq
);
  logic            rx_cond;
  logic            tx_cond;
  logic [NDIR-1:0] cond_v;
  logic [NDIR-1:0] clr_v;
  logic [NDIR-1:0] pend_v;

  irq_rx_cond #(.DEPTH(DEPTH), .CW(CW)) u_rx_cond (
    .en(mod_en), .level(rx_level), .rd(rx_rd), .sel(rx_sel),
    .drain_all(rx_drain_all), .cond(rx_cond)
  );

  irq_tx_cond #(.DEPTH(DEPTH), .CW(CW)) u_tx_cond (
    .en(mod_en), .level(tx_level), .wr(tx_wr), .sel(tx_sel),
    .shift_busy(tx_shift_busy), .cond(tx_cond)
  );

  assign cond_v[DIR_RX] = rx_cond;
  assign cond_v[DIR_TX] = tx_cond;
  assign clr_v          = clr_mask & {NDIR{clr_we}};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    irq_pend_flag u_flag (
      .clk(clk), .rst_n(rst_n), .cond(cond_v[d]), .clr(clr_v[d]),
      .pend(pend_v[d])
    );
  end

  assign rx_pend = pend_v[DIR_RX];
  assign tx_pend = pend_v[DIR_TX];
  assign rx_irq  = rx_pend && rx_ie;
  assign tx_irq  = tx_pend && tx_ie;
endmodule

// File: rtl/irq_persist_flags_chk.sv
module irq_persist_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mod_en,
  input logic       rx_cond,
  input logic       tx_cond,
  input logic       clr_we,
  input logic [1:0] clr_mask,
  input logic       rx_ie,
  input logic       tx_ie,
  input logic       rx_pend,
  input logic       tx_pend,
  input logic       rx_irq,
  input logic       tx_irq
);
  assert_rx_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cond |=> rx_pend);
  assert_tx_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cond |=> tx_pend);
  assert_rx_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_pend && !rx_cond) |=> !rx_pend);
  assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pend && !(clr_we && clr_mask[0])) |=> rx_pend);
  assert_rx_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pend && clr_we && clr_mask[0] && !rx_cond) |=> !rx_pend);
  assert_tx_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pend && clr_we && clr_mask[1] && !tx_cond) |=> !tx_pend);
  assert_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> (!rx_cond && !tx_cond));
  assert_rx_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_pend && rx_ie));
  assert_tx_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pend && tx_ie) |-> tx_irq);
endmodule

bind irq_persist_flags irq_persist_flags_chk u_chk (.*);

// File: tb/irq_persist_flags_bench.sv
`timescale 1ns/1ps
module irq_persist_flags_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 0, rx_drain_all = 0, rx_rd = 0, tx_wr = 0, tx_shift_busy = 0;
  logic clr_we = 0, rx_ie = 0, tx_ie = 0;
  logic [1:0] rx_sel = 0, tx_sel = 0, clr_mask = 0;
  logic [3:0] rx_level = 0, tx_level = 0;
  logic rx_pend, tx_pend, rx_irq, tx_irq;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;
  string phase = "R11";
  bit m_rx = 0, m_tx = 0;

  always #4 clk = ~clk;

  irq_persist_flags u_irq_persist_flags (.*);

  function automatic bit rx_fn(int lvl, bit rd, int sel, bit drain, bit en);
    int e = (rd && lvl > 0) ? lvl - 1 : lvl;
    int need;
    if (!en) return 0;
    if (drain) return e > 0;
    need = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 6 : 8;
    return e >= need;
  endfunction

  function automatic bit tx_fn(int lvl, bit wr, int sel, bit busy, bit en);
    int e = (wr && lvl < 8) ? lvl + 1 : lvl;
    if (!en) return 0;
    case (sel)
      0: return e < 8;
      1: return e == 0;
      2: return e <= 4;
      default: return (e == 0) && !busy;
    endcase
  endfunction

  always @(posedge clk) begin
    bit rc, tc;
    cycles++;
    if (!rst_n) begin m_rx = 0; m_tx = 0; end
    else begin
      rc = rx_fn(rx_level, rx_rd, rx_sel, rx_drain_all, mod_en);
      tc = tx_fn(tx_level, tx_wr, tx_sel, tx_shift_busy, mod_en);
      m_rx = rc || (m_rx && !(clr_we && clr_mask[0]));
      m_tx = tc || (m_tx && !(clr_we && clr_mask[1]));
    end
  end

  task automatic chk(string req, string what, bit act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // one clock; compare every output with the model at the following falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(phase, "rx_pend", rx_pend, m_rx);
    chk(phase, "tx_pend", tx_pend, m_tx);
    chk("R9", "rx_irq", rx_irq, m_rx && rx_ie);
    chk("R9", "tx_irq", tx_irq, m_tx && tx_ie);
    clr_we = 0; rx_rd = 0; tx_wr = 0;
  endtask

  task automatic clear(logic [1:0] m);
    clr_we = 1; clr_mask = m; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    tx_level = 8;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R11", "rx_pend after reset", rx_pend, 0);
    chk("R11", "tx_pend after reset", tx_pend, 0);

    // R7: enabling with an empty transmit FIFO raises tx for every select
    for (int s = 0; s < 4; s++) begin
      phase = "R7"; mod_en = 0; tx_level = 0; tx_sel = s[1:0];
      clear(2'b11);
      mod_en = 1; tick();
      chk("R7", "tx_pend after enable", tx_pend, 1);
    end

    // R2: clear blocked while tx condition holds, accepted once filled
    phase = "R2"; tx_sel = 0; tx_level = 0;
    clear(2'b10);
    chk("R2", "tx clear while empty", tx_pend, 1);
    tx_level = 8; clear(2'b10);
    chk("R2", "tx clear when full", tx_pend, 0);

    // R3: receive thresholds, every level for every select
    phase = "R3";
    for (int s = 0; s < 4; s++)
      for (int l = 0; l <= 8; l++) begin
        rx_sel = s[1:0]; rx_level = l[3:0];
        tick(); clear(2'b01);
        rx_level = 0; clear(2'b01);
      end

    // R4: read strobe drops the count below the level in the clearing cycle
    phase = "R4"; rx_sel = 1; rx_level = 4; tick();
    chk("R4", "rx set at 4 of half", rx_pend, 1);
    clr_we = 1; clr_mask = 2'b01; rx_rd = 1; tick();
    chk("R4", "rx clear with read at boundary", rx_pend, 0);
    rx_level = 5; clr_we = 1; clr_mask = 2'b01; rx_rd = 1; tick();
    chk("R4", "rx clear with read above boundary", rx_pend, 1);
    rx_level = 0; clear(2'b01);

    // R5: transmit thresholds, every level for every select, busy both ways
    phase = "R5";
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 4; s++)
        for (int l = 0; l <= 8; l++) begin
          tx_shift_busy = b[0]; tx_sel = s[1:0]; tx_level = l[3:0];
          tick(); clear(2'b10);
          tx_level = 8; clear(2'b10);
        end
    tx_shift_busy = 0;

    // R6: write strobe lifts the count past the level in the clearing cycle
    phase = "R6"; tx_sel = 2; tx_level = 4; tick();
    chk("R6", "tx set at 4 of low", tx_pend, 1);
    clr_we = 1; clr_mask = 2'b10; tx_wr = 1; tick();
    chk("R6", "tx clear with write at boundary", tx_pend, 0);
    tx_level = 8;

    // R8: drain mode ignores the select field
    phase = "R8"; rx_sel = 3; rx_drain_all = 1; rx_level = 1; tick();
    chk("R8", "rx set by one entry in drain mode", rx_pend, 1);
    clear(2'b01);
    chk("R8", "rx clear blocked with entry left", rx_pend, 1);
    clr_we = 1; clr_mask = 2'b01; rx_rd = 1; tick();
    chk("R8", "rx clear with last read", rx_pend, 0);
    rx_level = 0; rx_drain_all = 0;

    // R9: enable gates the request, dropping it keeps the flag
    phase = "R9"; rx_level = 8; rx_ie = 1; tick();
    chk("R9", "rx_irq with enable", rx_irq, 1);
    rx_ie = 0; tick();
    chk("R9", "rx_irq masked", rx_irq, 0);
    chk("R9", "rx_pend kept when masked", rx_pend, 1);

    // R10: disabled module lets stale flags clear
    phase = "R10"; tx_level = 0; tick();
    mod_en = 0; clear(2'b11);
    chk("R10", "rx clear while disabled", rx_pend, 0);
    chk("R10", "tx clear while disabled", tx_pend, 0);

    // R1: random traffic against the model
    phase = "R1"; mod_en = 1;
    for (int i = 0; i < 3000; i++) begin
      rx_level = 4'($urandom_range(0, 8)); tx_level = 4'($urandom_range(0, 8));
      rx_sel = 2'($urandom); tx_sel = 2'($urandom);
      rx_rd = 1'($urandom); tx_wr = 1'($urandom);
      clr_we = 1'($urandom); clr_mask = 2'($urandom);
      rx_ie = 1'($urandom); tx_ie = 1'($urandom);
      tx_shift_busy = 1'($urandom); rx_drain_all = ($urandom_range(0, 7) == 0);
      mod_en = ($urandom_range(0, 15) != 0);
      tick();
    end
    finish_run();
  end
endmodule